// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is the register bank of a two-channel disk controller, reached through a pair of byte ports. The host writes a register number to the index port at offset 0. It then reads or writes the chosen byte through the data port at offset 4. The bank holds:

- four fixed identification bytes;
- a configuration byte carrying the silicon revision, a strap bit and the primary interrupt-pending flag;
- a channel control byte;
- the command and per-drive timing bytes;
- a burst-size byte;
- a scratch byte.

The block drives the decoded control bits to the rest of the controller: the secondary channel enable and four per-drive prefetch-disable bits. It also registers the two channel interrupt lines and shows them both as outputs and as read-only flags inside the bank. Reads complete in the same cycle the port is addressed. Writes take effect at the next clock edge.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the index reads 0x00, the burst byte (0x59) reads 0x40, every other writable byte reads 0x00, `pf_off` is 0000 and `sec_en` is 0.
- R2: A write at offset 0 latches the index, and a read at offset 0 returns the latched index.
- R3: Through offset 4, indexes 0x00, 0x01, 0x02 and 0x03 read 0x95, 0x10, 0x40 and 0x06, and writes to them are ignored.
- R4: Index 0x50 reads {2'b00, ALT_BASE, 2'b00, primary flag, REV[1:0]}, with the primary flag at bit 2 and the strap at bit 5. Writes to this byte are ignored.
- R5: `irq_pend[0]` and `irq_pend[1]` equal `irq_pri` and `irq_sec` one clock earlier. The secondary flag reads as bit 4 of index 0x57, and writes to that bit are ignored.
- R6: Index 0x51 is read/write. Bit 3 drives `sec_en`, bit 6 drives `pf_off[0]` and bit 7 drives `pf_off[1]`.
- R7: Bits 2 and 3 of index 0x57 are read/write and drive `pf_off[2]` and `pf_off[3]`. The other non-flag bits of 0x57 read back as written.
- R8: Indexes 0x52 through 0x56, 0x58 and 0x59 read back the last byte written to them.
- R9: Index 0x5B is a scratch byte that returns the last value written.
- R10: Any other index (for example 0x04, 0x5A, 0x60) reads 0x00, and a write to it changes no implemented byte.
- R11: Offsets other than 0 and 4 read 0x00, and writes there change neither the index nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Byte offset from the port base |
| bus_wr | input | 1 | Write strobe for the addressed offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed offset (combinational) |
| irq_pri | input | 1 | Primary channel interrupt line |
| irq_sec | input | 1 | Secondary channel interrupt line |
| irq_pend | output | 2 | Registered interrupt flags {secondary, primary} |
| pf_off | output | 4 | Prefetch disable per drive 3..0 |
| sec_en | output | 1 | Secondary channel enable |

## Verification
A corrupted index shows up at once: the next read at offset 0 and every data-port read after it return the wrong byte. A bad write mask or a bad slot decode leaves a timing, control or scratch byte wrong. This can surface much later, either when that byte is read back or in the decoded `pf_off` and `sec_en` outputs, which follow one edge after the write. A stale interrupt flag shows at `irq_pend` one edge after the line changes, and in the 0x50 and 0x57 reads that follow.

// File: rtl/cfg_index_port.sv
module cfg_index_port #(
  parameter logic [1:0] REV       = 2'd2,
  parameter bit         ALT_BASE  = 1'b0,
  parameter logic [7:0] BURST_RST = 8'h40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       irq_pri,
  input  logic       irq_sec,
  output logic [1:0] irq_pend,
  output logic [3:0] pf_off,
  output logic       sec_en
);
  localparam logic [7:0] BANK_BASE = 8'h50;
  localparam int         BANK_N    = 12;
  localparam logic [2:0] IDX_OFS   = 3'd0;
  localparam logic [2:0] DAT_OFS   = 3'd4;
  localparam int         S_CFG     = 0;
  localparam int         S_CTL     = 1;
  localparam int         S_SEC     = 7;
  localparam int         S_BURST   = 9;
  localparam int         S_HOLE    = 10;

  function automatic logic [7:0] wmask(input int s);
    case (s)
      S_CFG, S_HOLE: return 8'h00;
      S_SEC:         return 8'hEF;
      default:       return 8'hFF;
    endcase
  endfunction

  logic [7:0] idx_q;
  logic [1:0] irq_q;
  logic [7:0] bank_q [BANK_N];
  logic [7:0] dat_byte;

  wire       idx_wr  = bus_wr && bus_addr == IDX_OFS;
  wire       dat_wr  = bus_wr && bus_addr == DAT_OFS;
  wire       in_bank = idx_q >= BANK_BASE && idx_q < BANK_BASE + 8'(BANK_N);
  wire [3:0] slot    = idx_q[3:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
      irq_q <= 2'b00;
      for (int i = 0; i < BANK_N; i++)
        bank_q[i] <= (i == S_BURST) ? BURST_RST : 8'h00;
    end else begin
      irq_q <= {irq_sec, irq_pri};
      if (idx_wr) idx_q <= bus_wdata;
      for (int i = 0; i < BANK_N; i++)
        if (dat_wr && in_bank && int'(slot) == i)
          bank_q[i] <= (bank_q[i] & ~wmask(i)) | (bus_wdata & wmask(i));
    end
  end

  always_comb begin
    dat_byte = 8'h00;
    case (idx_q)
      8'h00: dat_byte = 8'h95;
      8'h01: dat_byte = 8'h10;
      8'h02: dat_byte = 8'h40;
      8'h03: dat_byte = 8'h06;
      default: begin
        if (in_bank) begin
          case (int'(slot))
            S_CFG:   dat_byte = {2'b00, ALT_BASE, 2'b00, irq_q[0], REV};
            S_SEC:   dat_byte = {bank_q[S_SEC][7:5], irq_q[1], bank_q[S_SEC][3:0]};
            S_HOLE:  dat_byte = 8'h00;
            default: dat_byte = bank_q[slot];
          endcase
        end
      end
    endcase
  end

  assign bus_rdata = (bus_addr == IDX_OFS) ? idx_q :
                     (bus_addr == DAT_OFS) ? dat_byte : 8'h00;
  assign irq_pend  = irq_q;
  assign sec_en    = bank_q[S_CTL][3];
  assign pf_off    = {bank_q[S_SEC][3], bank_q[S_SEC][2], bank_q[S_CTL][7], bank_q[S_CTL][6]};
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       irq_pri,
  input logic       irq_sec,
  input logic [1:0] irq_pend,
  input logic [3:0] pf_off,
  input logic       sec_en,
  input logic [7:0] idx
);
  assert_index_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0) |=> (idx == $past(bus_wdata)));

  assert_id_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd4 && idx == 8'h00) |-> (bus_rdata == 8'h95));

  assert_irq_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_pend == $past({irq_sec, irq_pri})));

  assert_ctl_decode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd4 && idx == 8'h51) |=>
      (sec_en == $past(bus_wdata[3]) && pf_off[1:0] == $past(bus_wdata[7:6])));

  assert_pf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 3'd4) |=> $stable(pf_off));

  assert_hole_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd4 && idx == 8'h5A) |-> (bus_rdata == 8'h00));

  assert_other_ofs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != 3'd0) |=> $stable(idx));
endmodule

bind cfg_index_port cfg_index_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pri(irq_pri),
  .irq_sec(irq_sec), .irq_pend(irq_pend), .pf_off(pf_off),
  .sec_en(sec_en), .idx(idx_q)
);

// File: tb/sim_cfg_index_port.sv
`timescale 1ns/1ps
module sim_cfg_index_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_pri = 1'b0;
  logic       irq_sec = 1'b0;
  logic [1:0] irq_pend;
  logic [3:0] pf_off;
  logic       sec_en;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  cfg_index_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pri(irq_pri),
    .irq_sec(irq_sec), .irq_pend(irq_pend), .pf_off(pf_off), .sec_en(sec_en)
  );

  task automatic wr_port(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] i, input logic [7:0] d);
    wr_port(3'd0, i);
    wr_port(3'd4, d);
  endtask

  task automatic expect_at(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic expect_rd(input logic [7:0] i, input logic [7:0] e, input string t);
    wr_port(3'd0, i);
    bus_addr = 3'd4;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic check(input string t, input logic [7:0] act, input logic [7:0] e);
    #1;
    checks++;
    if (act !== e) begin
      errs++;
      $display("FAIL %s actual=%02h expected=%02h", t, act, e);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          errs++;
          $display("FAIL %s actual=%02h expected=%02h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_at(3'd0, 8'h00, "R1 index after reset");
    check("R1 pf_off after reset", {4'h0, pf_off}, 8'h00);
    check("R1 sec_en after reset", {7'h0, sec_en}, 8'h00);
    expect_rd(8'h59, 8'h40, "R1 burst reset");
    expect_rd(8'h51, 8'h00, "R1 control reset");
    expect_rd(8'h5B, 8'h00, "R1 scratch reset");
    // R2 index echo
    wr_port(3'd0, 8'hA7);
    expect_at(3'd0, 8'hA7, "R2 index echo");
    // R3 identification bytes
    expect_rd(8'h00, 8'h95, "R3 id0");
    expect_rd(8'h01, 8'h10, "R3 id1");
    expect_rd(8'h02, 8'h40, "R3 id2");
    set_reg(8'h03, 8'hFF);
    expect_at(3'd4, 8'h06, "R3 id3 after write");
    // R4 configuration byte
    expect_rd(8'h50, 8'h02, "R4 cfg revision");
    set_reg(8'h50, 8'hFF);
    expect_at(3'd4, 8'h02, "R4 cfg write ignored");
    // R5 interrupt flags
    @(negedge clk);
    irq_pri = 1'b1;
    expect_rd(8'h50, 8'h06, "R5 primary flag in cfg");
    check("R5 irq_pend primary", {6'h0, irq_pend}, 8'h01);
    irq_pri = 1'b0;
    irq_sec = 1'b1;
    set_reg(8'h57, 8'h00);
    expect_at(3'd4, 8'h10, "R5 secondary flag survives write");
    check("R5 irq_pend secondary", {6'h0, irq_pend}, 8'h02);
    irq_sec = 1'b0;
    expect_rd(8'h57, 8'h00, "R5 secondary flag clears");
    // R6 control byte
    set_reg(8'h51, 8'hC8);
    check("R6 sec_en", {7'h0, sec_en}, 8'h01);
    check("R6 pf_off primary", {4'h0, pf_off}, 8'h03);
    expect_at(3'd4, 8'hC8, "R6 control readback");
    set_reg(8'h51, 8'h40);
    check("R6 pf_off drive0 only", {4'h0, pf_off}, 8'h01);
    check("R6 sec_en cleared", {7'h0, sec_en}, 8'h00);
    // R7 secondary prefetch bits
    set_reg(8'h57, 8'hFF);
    check("R7 pf_off all", {4'h0, pf_off}, 8'h0D);
    expect_at(3'd4, 8'hEF, "R7 0x57 readback");
    set_reg(8'h57, 8'h04);
    check("R7 pf_off drive2", {4'h0, pf_off}, 8'h05);
    // R8 timing bytes
    for (int i = 0; i < 5; i++) set_reg(8'h52 + 8'(i), 8'h30 + 8'(i * 7));
    set_reg(8'h58, 8'h5C);
    set_reg(8'h59, 8'h00);
    for (int i = 0; i < 5; i++) expect_rd(8'h52 + 8'(i), 8'h30 + 8'(i * 7), "R8 timing readback");
    expect_rd(8'h58, 8'h5C, "R8 shared timing readback");
    expect_rd(8'h59, 8'h00, "R8 burst readback");
    // R9 scratch
    set_reg(8'h5B, 8'hBD);
    expect_at(3'd4, 8'hBD, "R9 scratch BD");
    set_reg(8'h5B, 8'h00);
    expect_at(3'd4, 8'h00, "R9 scratch cleared");
    // R10 unimplemented indexes
    set_reg(8'h5A, 8'hAA);
    expect_at(3'd4, 8'h00, "R10 hole 0x5A");
    expect_rd(8'h59, 8'h00, "R10 neighbour 0x59 untouched");
    expect_rd(8'h5B, 8'h00, "R10 neighbour 0x5B untouched");
    set_reg(8'h04, 8'h77);
    expect_at(3'd4, 8'h00, "R10 index 0x04");
    set_reg(8'h60, 8'h77);
    expect_at(3'd4, 8'h00, "R10 index 0x60");
    // R11 other offsets
    wr_port(3'd0, 8'h51);
    wr_port(3'd2, 8'h99);
    wr_port(3'd5, 8'h99);
    expect_at(3'd2, 8'h00, "R11 offset 2 reads zero");
    expect_at(3'd0, 8'h51, "R11 index unchanged");
    expect_at(3'd4, 8'h40, "R11 control unchanged");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule